// File: doc/BRIEF.md
# Interrupt Source Presented/Queued State Controller

This block keeps the delivery state of a bank of interrupt sources. Each source is either message-type, where every trigger is a discrete event, or level-type, where the source is asserted or deasserted. Per source the block holds a two-bit state: a Presented flag and a Queued flag. Repeated message triggers fold into at most one queued re-delivery, which fires when the source is acknowledged with an end-of-interrupt (EOI). For level sources the Presented flag also serves as the "line is asserted" memory.

Whenever a source has to be delivered, the block raises a one-cycle present request, tagged with the source index, toward a downstream presentation unit. Each source's state can be read out as a 64-bit save word and written back from such a word. This lets a context be moved between instances. Source existence is a static configuration bitmap. Any operation aimed at a source that does not exist is refused.

Top module: `pq_src_ctrl`

## Requirements
- R1: After reset every source holds state 00 (bit 0 = Presented, bit 1 = Queued), is message-type and unmasked. `pres_valid` and `err` are low.
- R2: A trigger (`evt_level`=1) on a message source sets the new state to ((old << 1) & 3) | 1. A present request is raised only when the new state is exactly 01.
- R3: An event with `evt_level`=0 on a message source leaves the state unchanged and raises no present request.
- R4: An assert (`evt_level`=1) on a level source with Presented already set changes nothing and raises no request. With Presented clear, the state becomes 01 and a present request is raised.
- R5: A deassert (`evt_level`=0) on a level source clears the state to 00 and raises no request.
- R6: An EOI on a message source shifts the state right by one, so Queued moves into Presented and Queued clears. A present request is raised if the resulting Presented is 1.
- R7: An EOI on a level source leaves the state unchanged. A present request is raised if Presented is 1.
- R8: `sv_word` shows the source selected by `sv_idx` on the same cycle, with these bits: 40 = level-type, 41 = masked, 42 = pending (equal to Presented for a level source, 0 for a message source), 43 = Presented, 44 = Queued. All other bits are 0.
- R9: A restore sets level-type from bit 40 and masked from bit 41. It sets Presented if bit 43 or bit 42 is 1, and Queued from bit 44. All other bits are ignored, and a restore raises no present request.
- R10: An event, EOI or restore whose index is not marked in `src_exists` gives a one-cycle `err` pulse on the next cycle. It changes no state and raises no present request.
- R11: When an EOI and an event target the same source in the same cycle, the EOI step is applied first and the event step is applied to its result.
- R12: A present request appears on `pres_valid`/`pres_idx` one cycle after the input that caused it, and at most one request is issued per cycle. An EOI request wins. A request that cannot be issued is deferred and issued later, exactly once. When several requests are deferred, the lowest index goes first. Deferred requests go ahead of a new event request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_exists | input | NUM_SRC | Static bitmap of existing sources |
| evt_valid | input | 1 | Event strobe |
| evt_idx | input | IDX_W | Event source index |
| evt_level | input | 1 | 1 = trigger/assert, 0 = deassert |
| eoi_valid | input | 1 | EOI strobe |
| eoi_idx | input | IDX_W | EOI source index |
| ld_valid | input | 1 | Restore strobe |
| ld_idx | input | IDX_W | Restore source index |
| ld_word | input | 64 | Restore word |
| sv_idx | input | IDX_W | Save read index |
| sv_word | output | 64 | Save word of the selected source |
| pres_valid | output | 1 | Present request |
| pres_idx | output | IDX_W | Source index of the present request |
| err | output | 1 | Rejected-operation pulse |

## Verification
The assertions assume that a restore never targets the same source as an event or an EOI in the same cycle, and that `src_exists` stays fixed while the block is running. One property checks the first assumption directly. The bench keeps to both: it sets the existence bitmap before reset and never changes it. It also issues every restore in a cycle of its own, apart from any event or EOI. Software-style misuse is outside what the properties cover, such as an EOI sent for a source whose request is still deferred. The bench does not produce that case.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

    // Save-word bit positions; external software decodes them.
    localparam int unsigned WB_LVL = 40;
    localparam int unsigned WB_MSK = 41;
    localparam int unsigned WB_PND = 42;
    localparam int unsigned WB_PRS = 43;
    localparam int unsigned WB_QUE = 44;

    // State bit positions inside the 2-bit source state.
    localparam int unsigned SB_P = 0;
    localparam int unsigned SB_Q = 1;

    typedef struct packed {
        logic [1:0] pq;
        logic       pres;
    } step_t;

    // Event step: level=1 is trigger/assert, level=0 is deassert.
    function automatic step_t trig_step(input logic [1:0] pq, input logic is_lvl,
                                        input logic level);
        step_t r;
        r.pq   = pq;
        r.pres = 1'b0;
        if (is_lvl) begin
            if (!level) begin
                r.pq = 2'b00;
            end else if (!pq[SB_P]) begin
                r.pq   = 2'b01;
                r.pres = 1'b1;
            end
        end else if (level) begin
            r.pq   = {pq[SB_P], 1'b1};
            r.pres = (pq[SB_P] == 1'b0);
        end
        return r;
    endfunction

    // EOI step.
    function automatic step_t eoi_step(input logic [1:0] pq, input logic is_lvl);
        step_t r;
        if (is_lvl) begin
            r.pq   = pq;
            r.pres = pq[SB_P];
        end else begin
            r.pq   = {1'b0, pq[SB_Q]};
            r.pres = pq[SB_Q];
        end
        return r;
    endfunction

endpackage

// File: rtl/pq_word_codec.sv
module pq_word_codec
    import pq_src_pkg::*;
(
    input  logic [1:0]  sv_pq,
    input  logic        sv_lvl,
    input  logic        sv_msk,
    output logic [63:0] sv_word,
    input  logic [4:0]  ld_bits,   // restore word bits 44..40
    output logic [1:0]  ld_pq,
    output logic        ld_lvl,
    output logic        ld_msk
);
    localparam int unsigned OFS = WB_LVL;

    always_comb begin
        sv_word         = '0;
        sv_word[WB_LVL] = sv_lvl;
        sv_word[WB_MSK] = sv_msk;
        sv_word[WB_PND] = sv_lvl & sv_pq[SB_P];
        sv_word[WB_PRS] = sv_pq[SB_P];
        sv_word[WB_QUE] = sv_pq[SB_Q];
    end

    always_comb begin
        ld_lvl        = ld_bits[WB_LVL - OFS];
        ld_msk        = ld_bits[WB_MSK - OFS];
        ld_pq[SB_P]   = ld_bits[WB_PRS - OFS] | ld_bits[WB_PND - OFS];
        ld_pq[SB_Q]   = ld_bits[WB_QUE - OFS];
    end
endmodule

// File: rtl/pq_present_sched.sv
module pq_present_sched #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_req,
    input  logic [IDX_W-1:0] eoi_idx,
    input  logic             evt_req,
    input  logic [IDX_W-1:0] evt_idx,
    output logic             pres_valid,
    output logic [IDX_W-1:0] pres_idx
);
    typedef struct packed {
        logic [NUM_SRC-1:0] bl;
        logic               v;
        logic [IDX_W-1:0]   idx;
    } sch_t;

    sch_t             sch_d, sch_q;
    logic             found;
    logic [IDX_W-1:0] pick;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (sch_q.bl[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        sch_d     = sch_q;
        sch_d.v   = 1'b0;
        if (eoi_req) begin
            sch_d.v   = 1'b1;
            sch_d.idx = eoi_idx;
            if (evt_req) sch_d.bl[evt_idx] = 1'b1;
        end else if (found) begin
            sch_d.v        = 1'b1;
            sch_d.idx      = pick;
            sch_d.bl[pick] = 1'b0;
            if (evt_req) sch_d.bl[evt_idx] = 1'b1;
        end else if (evt_req) begin
            sch_d.v   = 1'b1;
            sch_d.idx = evt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sch_q <= '0;
        else        sch_q <= sch_d;
    end

    assign pres_valid = sch_q.v;
    assign pres_idx   = sch_q.idx;

    a_r12_eoi_first: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_req |=> (pres_valid && pres_idx == $past(eoi_idx)));

    a_r12_deferred_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && evt_req) |=> sch_q.bl[$past(evt_idx)]);
endmodule

// File: rtl/pq_src_ctrl.sv
module pq_src_ctrl
    import pq_src_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_exists,
    input  logic               evt_valid,
    input  logic [IDX_W-1:0]   evt_idx,
    input  logic               evt_level,
    input  logic               eoi_valid,
    input  logic [IDX_W-1:0]   eoi_idx,
    input  logic               ld_valid,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [63:0]        ld_word,
    input  logic [IDX_W-1:0]   sv_idx,
    output logic [63:0]        sv_word,
    output logic               pres_valid,
    output logic [IDX_W-1:0]   pres_idx,
    output logic               err
);
    localparam int unsigned CW = IDX_W + 1;

    typedef struct packed {
        logic [NUM_SRC-1:0][1:0] pq;
        logic [NUM_SRC-1:0]      lvl;
        logic [NUM_SRC-1:0]      msk;
        logic                    err;
    } bank_t;

    bank_t       st_d, st_q;
    step_t       s_eoi, s_evt;
    logic        eoi_ok, evt_ok, ld_ok;
    logic        eoi_pres, evt_pres;
    logic [1:0]  ld_pq;
    logic        ld_lvl, ld_msk;

    function automatic logic idx_ok(input logic [IDX_W-1:0] i, input logic [NUM_SRC-1:0] ex);
        return (CW'(i) < CW'(NUM_SRC)) && ex[i];
    endfunction

    assign eoi_ok = eoi_valid && idx_ok(eoi_idx, src_exists);
    assign evt_ok = evt_valid && idx_ok(evt_idx, src_exists);
    assign ld_ok  = ld_valid  && idx_ok(ld_idx,  src_exists);

    pq_word_codec u_codec (
        .sv_pq   (st_q.pq[sv_idx]),
        .sv_lvl  (st_q.lvl[sv_idx]),
        .sv_msk  (st_q.msk[sv_idx]),
        .sv_word (sv_word),
        .ld_bits (ld_word[WB_QUE:WB_LVL]),
        .ld_pq   (ld_pq),
        .ld_lvl  (ld_lvl),
        .ld_msk  (ld_msk)
    );

    always_comb begin
        st_d     = st_q;
        eoi_pres = 1'b0;
        evt_pres = 1'b0;
        s_eoi    = '0;
        s_evt    = '0;
        if (eoi_ok) begin
            s_eoi             = eoi_step(st_d.pq[eoi_idx], st_d.lvl[eoi_idx]);
            st_d.pq[eoi_idx]  = s_eoi.pq;
            eoi_pres          = s_eoi.pres;
        end
        if (evt_ok) begin
            s_evt             = trig_step(st_d.pq[evt_idx], st_d.lvl[evt_idx], evt_level);
            st_d.pq[evt_idx]  = s_evt.pq;
            evt_pres          = s_evt.pres;
        end
        if (ld_ok) begin
            st_d.pq[ld_idx]  = ld_pq;
            st_d.lvl[ld_idx] = ld_lvl;
            st_d.msk[ld_idx] = ld_msk;
        end
        st_d.err = (eoi_valid && !eoi_ok) || (evt_valid && !evt_ok) || (ld_valid && !ld_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err = st_q.err;

    pq_present_sched #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .eoi_req    (eoi_pres),
        .eoi_idx    (eoi_idx),
        .evt_req    (evt_pres),
        .evt_idx    (evt_idx),
        .pres_valid (pres_valid),
        .pres_idx   (pres_idx)
    );

    // Input assumption tied to R9: restore never shares a source with event/EOI.
    a_r9_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> !((evt_valid && evt_idx == ld_idx) || (eoi_valid && eoi_idx == ld_idx)));

    a_r9_restore_p: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ok |=> (st_q.pq[$past(ld_idx)][SB_P] == $past(ld_word[WB_PRS] | ld_word[WB_PND])));

    a_r2_msg_requeue: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ok && evt_level && !st_q.lvl[evt_idx] && st_q.pq[evt_idx][SB_P]
         && !(eoi_valid && eoi_idx == evt_idx))
        |=> (st_q.pq[$past(evt_idx)] == 2'b11));

    a_r5_lvl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ok && !evt_level && st_q.lvl[evt_idx]) |=> (st_q.pq[$past(evt_idx)] == 2'b00));

    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ok) |=> err);

    a_r10_state_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ok) |=> (st_q.pq[$past(evt_idx)] == $past(st_q.pq[evt_idx])));
endmodule

// File: tb/pq_src_ctrl_bench.sv
module pq_src_ctrl_bench;
    localparam int NUM = 8;
    localparam int IW  = 3;
    localparam logic [63:0] GARB = 64'hA5A5_E0FF_FFFF_FFFF; // bits 40..44 clear

    logic clk = 0, rst_n = 0;
    logic [NUM-1:0] src_exists = 8'h7F;
    logic evt_valid = 0, evt_level = 0, eoi_valid = 0, ld_valid = 0;
    logic [IW-1:0] evt_idx = 0, eoi_idx = 0, ld_idx = 0, sv_idx = 0;
    logic [63:0] ld_word = 0;
    logic [63:0] sv_word;
    logic pres_valid, err;
    logic [IW-1:0] pres_idx;

    int n_chk = 0, n_err = 0;
    logic g_pv, g_err;
    logic [IW-1:0] g_pi;
    logic [63:0] g_word;

    always #5 clk = ~clk;

    pq_src_ctrl #(.NUM_SRC(NUM), .IDX_W(IW)) u_pq_src_ctrl (
        .clk(clk), .rst_n(rst_n), .src_exists(src_exists),
        .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_level(evt_level),
        .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_word(ld_word),
        .sv_idx(sv_idx), .sv_word(sv_word),
        .pres_valid(pres_valid), .pres_idx(pres_idx), .err(err));

    task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", rq, got, exp);
        end
    endtask

    task automatic sample();
        g_pv = pres_valid; g_pi = pres_idx; g_err = err; g_word = sv_word;
    endtask

    task automatic step(input logic ev, input int ei, input logic el,
                        input logic ov, input int oi,
                        input logic lv, input int li, input logic [63:0] lw);
        @(negedge clk);
        evt_valid = ev; evt_idx = IW'(ei); evt_level = el;
        eoi_valid = ov; eoi_idx = IW'(oi);
        ld_valid = lv; ld_idx = IW'(li); ld_word = lw;
        @(posedge clk); #1;
        sample();
        evt_valid = 0; eoi_valid = 0; ld_valid = 0;
    endtask

    task automatic idle();
        @(posedge clk); #1; sample();
    endtask

    // Expected next state/present: op 0 = assert, 1 = deassert, 2 = EOI. Returns {pres, pq}.
    function automatic logic [2:0] mdl(input int s, input int lvl, input int op);
        int nv = s; int pr = 0;
        if (op == 0) begin
            if (lvl != 0) begin
                if (s % 2 == 1) nv = s; else begin nv = 1; pr = 1; end
            end else begin
                nv = ((s * 2) % 4) + 1; pr = (nv == 1);
            end
        end else if (op == 1) begin
            nv = (lvl != 0) ? 0 : s;
        end else begin
            if (lvl != 0) begin nv = s; pr = s % 2; end
            else begin nv = s / 2; pr = nv % 2; end
        end
        return {1'(pr), 2'(nv)};
    endfunction

    function automatic logic [63:0] word(input int s, input int lvl, input int msk);
        logic [63:0] w = 0;
        w[40] = 1'(lvl); w[41] = 1'(msk);
        w[42] = 1'(lvl) & 1'(s % 2);
        w[43] = 1'(s % 2); w[44] = 1'(s / 2);
        return w;
    endfunction

    function automatic logic [63:0] rword(input int s, input int lvl, input int msk, input int alt);
        logic [63:0] w = GARB;
        w[40] = 1'(lvl); w[41] = 1'(msk); w[44] = 1'(s / 2);
        if (s % 2 == 1) begin
            if (alt != 0) w[42] = 1'b1; else w[43] = 1'b1;
        end
        return w;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired got=1 exp=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [2:0] e;
        string rq;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1: reset state of all sources
        for (int i = 0; i < NUM; i++) begin
            sv_idx = IW'(i); #1;
            chk("R1 reset word", sv_word, 64'h0);
        end
        chk("R1 reset pres", {63'h0, pres_valid}, 64'h0);
        chk("R1 reset err", {63'h0, err}, 64'h0);

        // Sweep: type x state x op (R2..R9)
        for (int t = 0; t < 2; t++) begin
            for (int s = 0; s < 4; s++) begin
                for (int op = 0; op < 3; op++) begin
                    int src = (t * 12 + s * 3 + op) % 7;
                    int msk = (s % 2) ^ (op % 2);
                    sv_idx = IW'(src);
                    step(0, 0, 0, 0, 0, 1, src, rword(s, t, msk, op % 2));
                    chk("R9 restore word", g_word, word(s, t, msk));
                    chk("R9 restore no present", {63'h0, g_pv}, 64'h0);
                    e = mdl(s, t, op);
                    rq = (op == 0) ? (t != 0 ? "R4" : "R2") :
                         (op == 1) ? (t != 0 ? "R5" : "R3") : (t != 0 ? "R7" : "R6");
                    if (op == 2) step(0, 0, 0, 1, src, 0, 0, 0);
                    else         step(1, src, (op == 0), 0, 0, 0, 0, 0);
                    chk({rq, " state/R8 word"}, g_word, word(int'(e[1:0]), t, msk));
                    chk({rq, " present"}, {62'h0, g_pv, g_pv & (g_pi == IW'(src))},
                        {62'h0, e[2], e[2]});
                    chk({rq, " no err"}, {63'h0, g_err}, 64'h0);
                end
            end
        end

        // R11: EOI and trigger on the same message source in one cycle
        for (int s = 0; s < 4; s++) begin
            logic [2:0] e1, e2;
            sv_idx = 3'd5;
            step(0, 0, 0, 0, 0, 1, 5, rword(s, 0, 0, 0));
            e1 = mdl(s, 0, 2);
            e2 = mdl(int'(e1[1:0]), 0, 0);
            step(1, 5, 1, 1, 5, 0, 0, 0);
            chk("R11 state", g_word, word(int'(e2[1:0]), 0, 0));
            chk("R11 present", {63'h0, g_pv}, {63'h0, e1[2] | e2[2]});
            idle();
            chk("R11 single present", {63'h0, g_pv}, 64'h0);
        end

        // R12: collisions, EOI first, deferred lowest-first
        step(0, 0, 0, 0, 0, 1, 1, rword(1, 1, 0, 0));
        step(0, 0, 0, 0, 0, 1, 4, rword(1, 1, 0, 0));
        step(0, 0, 0, 0, 0, 1, 2, rword(0, 0, 0, 0));
        step(0, 0, 0, 0, 0, 1, 3, rword(0, 0, 0, 0));
        step(1, 3, 1, 1, 1, 0, 0, 0);
        chk("R12 eoi wins", {60'h0, g_pv, g_pi}, {60'h0, 1'b1, 3'd1});
        step(1, 2, 1, 1, 4, 0, 0, 0);
        chk("R12 eoi wins again", {60'h0, g_pv, g_pi}, {60'h0, 1'b1, 3'd4});
        idle();
        chk("R12 deferred low first", {60'h0, g_pv, g_pi}, {60'h0, 1'b1, 3'd2});
        idle();
        chk("R12 deferred next", {60'h0, g_pv, g_pi}, {60'h0, 1'b1, 3'd3});
        idle();
        chk("R12 drained", {63'h0, g_pv}, 64'h0);

        // R10: nonexistent source 7
        sv_idx = 3'd7;
        step(0, 0, 0, 0, 0, 1, 7, rword(3, 1, 1, 0));
        chk("R10 restore err", {63'h0, g_err}, 64'h1);
        chk("R10 restore no change", g_word, 64'h0);
        step(1, 7, 1, 0, 0, 0, 0, 0);
        chk("R10 event err", {63'h0, g_err}, 64'h1);
        chk("R10 event no present", {63'h0, g_pv}, 64'h0);
        step(0, 0, 0, 1, 7, 0, 0, 0);
        chk("R10 eoi err", {63'h0, g_err}, 64'h1);
        chk("R10 eoi no present", {63'h0, g_pv}, 64'h0);
        idle();
        chk("R10 err one cycle", {63'h0, g_err}, 64'h0);
        chk("R10 state kept", g_word, 64'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule